// File: doc/BRIEF.md
# Fractional baud tick generator

This block turns a clock into the timing strobes a serial receiver and transmitter need. The timing comes from a 12-bit integer divisor, a 7-bit fractional divisor counted in 1/128 steps, and an oversampling factor. The factor is picked by a small code and is a power of two. The block emits a one-cycle sample tick for each oversampling slot. It marks the last tick of every bit with a bit-end strobe and the tick in the middle of a bit with a half-bit strobe.

The period of each sample tick is the integer divisor, stretched by one clock whenever the fractional accumulator carries. An accuracy mode decides where the accumulator is cleared:
- In frame mode it runs through the whole character, so the error of the total character length stays within one clock.
- In bit mode it is cleared at every bit boundary, so every bit has exactly the same length.

A frame-start pulse restarts all counting. Counting is driven either by every cycle of the system clock or only by the cycles in which an alternate-clock enable is high. A static select input picks between the two sources.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low all three outputs are low. Reset leaves the block in the same state as a frame start, so with a divisor of 1 `sample_tick` is high in the first cycle that has `rst_n` high.
- R2: With `frac_div` = 0, `sample_tick` is a one-cycle pulse that repeats every `int_div` counted cycles.
- R3: With `acc_mode` = 0 (frame mode), the k-th tick after a frame start (k from 0) ends D + floor((k+1)·F/128) − floor(k·F/128) counted cycles after the previous tick or after the start. D is `int_div` and F is `frac_div`.
- R4: With `acc_mode` = 1 (bit mode), the same formula applies with k replaced by the tick's index inside its bit. Every bit therefore repeats the same sequence of periods.
- R5: `factor_code` 0, 1, 2 and 3 select 128, 64, 32 and 16 ticks per bit, and codes 4 to 7 select 16. `bit_end` is high together with every N-th tick of a bit, where N is the factor, and never at any other time.
- R6: `half_bit` is high together with tick number N/2 of each bit (counting from 1), and never at any other time.
- R7: With `int_div` = 0 no output is ever asserted, whatever the fractional field holds.
- R8: In a cycle with `frame_start` high all outputs are low. The tick counter, the fractional accumulator and the bit index restart from zero.
- R9: With `src_sel` = 1 only cycles with `alt_en` high are counted, and outputs can only be high in such cycles. With `src_sel` = 0 every cycle counts and `alt_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 1 | 0: count every clock; 1: count only cycles with `alt_en` |
| alt_en | input | 1 | Qualifier standing in for the alternate clock |
| int_div | input | 12 | Integer divisor in clocks per tick; 0 stops the block |
| frac_div | input | 7 | Fractional divisor in 1/128 clock units |
| factor_code | input | 3 | Oversampling factor select (128 >> code, minimum 16) |
| acc_mode | input | 1 | 0: frame accuracy; 1: bit accuracy |
| frame_start | input | 1 | Restart of tick, bit and accumulator state |
| sample_tick | output | 1 | Oversampling tick, one cycle wide |
| bit_end | output | 1 | High with the last tick of each bit |
| half_bit | output | 1 | High with the middle tick of each bit |

## Verification
Directed cases come first:
- A zero fractional field isolates the plain integer period.
- Fractional values of 37 and 127 put carries at irregular tick positions.
- The same value of 37 is run in both accuracy modes with a factor of 16. The two modes produce different periods from the second bit on, so an accumulator that is cleared in the wrong place is caught.
- Factor codes 0 and 5 check the widest bit and the clamping of oversized codes.

Random cases then mix divisor, fraction, code, mode and clock source. A random `alt_en` runs under both source settings, which shows that gating happens with source 1 and that `alt_en` is ignored with source 0. Each case opens with a frame start that lands at an arbitrary point of the previous case, and that checks the full restart.

// File: rtl/baud_tick_pkg.sv
// Shared definitions for the fractional baud tick generator.
// Assumes: nothing beyond standard SystemVerilog.
package baud_tick_pkg;

    // Default geometry of the divisor fields and the factor code.
    localparam int DEF_DIV_W    = 12;
    localparam int DEF_FRAC_W   = 7;
    localparam int DEF_CODE_W   = 3;
    localparam int DEF_FLOG_MAX = 7;   // log2 of the largest factor (128)
    localparam int DEF_FLOG_MIN = 4;   // log2 of the smallest factor (16)

    // Where the fractional remainder is cleared.
    typedef enum logic {
        ACC_FRAME = 1'b0,
        ACC_BIT   = 1'b1
    } acc_mode_e;

endpackage

// File: rtl/baud_period_ctr.sv
// Tick period counter: counts qualified clocks and fires a tick after
// int_div + carry of them. Assumes carry is stable during a period
// (it comes from a register that only moves on a tick).
module baud_period_ctr #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             qual,
    input  logic [DIV_W-1:0] int_div,
    input  logic             carry,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          active;
    logic          at_last;

    // Last count value of the current period; >= tolerates a divisor shrinking mid-period.
    always_comb begin
        active  = (int_div != '0);
        last    = CW'(int_div) + CW'(carry) - CW'(1);
        at_last = (cnt >= last);
        tick    = rst_n && active && !restart && qual && at_last;
    end

    // Advance on qualified clocks, wrap on the tick, clear on restart or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !active) begin
            cnt <= '0;
        end else if (qual) begin
            cnt <= at_last ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/baud_frac_acc.sv
// Fractional accumulator: adds frac on every tick and reports a carry that
// lengthens the next tick period by one clock. Cleared on restart and,
// in bit mode, on the tick that ends a bit.
module baud_frac_acc #(
    parameter int FRAC_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic              bit_wrap,
    input  logic              bit_mode,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    // Sum of the running remainder and the fraction; the top bit is the carry.
    always_comb begin
        sum   = {1'b0, acc} + {1'b0, frac};
        carry = sum[FRAC_W];
    end

    // Keep the remainder; clear it where the accuracy mode says so.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (restart) begin
            acc <= '0;
        end else if (tick) begin
            acc <= (bit_mode && bit_wrap) ? '0 : sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/baud_bit_ctr.sv
// Bit slot counter: counts ticks within a bit, decodes the factor code
// (128 >> code, clamped at the smallest factor) and marks the middle and
// last tick of each bit. Assumes the factor is at least 2.
module baud_bit_ctr #(
    parameter int CODE_W   = 3,
    parameter int FLOG_MAX = 7,
    parameter int FLOG_MIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [CODE_W-1:0] factor_code,
    output logic              bit_end,
    output logic              half_bit
);
    localparam int SPAN = FLOG_MAX - FLOG_MIN;
    localparam int IW   = FLOG_MAX;

    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;
    logic [IW-1:0] half_idx;
    int            sh;

    // Decode the factor into the index of the last and the middle tick.
    always_comb begin
        sh       = (int'(factor_code) > SPAN) ? SPAN : int'(factor_code);
        last_idx = IW'((1 << (FLOG_MAX - sh)) - 1);
        half_idx = IW'((1 << (FLOG_MAX - sh - 1)) - 1);
        bit_end  = tick && (idx >= last_idx);
        half_bit = tick && (idx == half_idx);
    end

    // Step the tick index, wrapping at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (restart) begin
            idx <= '0;
        end else if (tick) begin
            idx <= bit_end ? '0 : idx + IW'(1);
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
// Fractional baud tick generator top. Selects the counting source, then
// chains the period counter, fractional accumulator and bit counter.
// Assumes src_sel is static while running; alt_en is already synchronous to clk.
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int DIV_W    = DEF_DIV_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    parameter int CODE_W   = DEF_CODE_W,
    parameter int FLOG_MAX = DEF_FLOG_MAX,
    parameter int FLOG_MIN = DEF_FLOG_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_sel,
    input  logic              alt_en,
    input  logic [DIV_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] frac_div,
    input  logic [CODE_W-1:0] factor_code,
    input  logic              acc_mode,
    input  logic              frame_start,
    output logic              sample_tick,
    output logic              bit_end,
    output logic              half_bit
);
    logic qual;
    logic bit_mode;
    logic carry;
    logic tick;
    logic wrap;
    logic mid;

    // Source select treated as a static enable on the count.
    always_comb begin
        qual     = src_sel ? alt_en : 1'b1;
        bit_mode = (acc_mode == ACC_BIT);
    end

    baud_period_ctr #(.DIV_W(DIV_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_start),
        .qual    (qual),
        .int_div (int_div),
        .carry   (carry),
        .tick    (tick)
    );

    baud_frac_acc #(.FRAC_W(FRAC_W)) u_frac (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (frame_start),
        .tick     (tick),
        .bit_wrap (wrap),
        .bit_mode (bit_mode),
        .frac     (frac_div),
        .carry    (carry)
    );

    baud_bit_ctr #(
        .CODE_W   (CODE_W),
        .FLOG_MAX (FLOG_MAX),
        .FLOG_MIN (FLOG_MIN)
    ) u_bit (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (frame_start),
        .tick        (tick),
        .factor_code (factor_code),
        .bit_end     (wrap),
        .half_bit    (mid)
    );

    // Drive the outputs.
    always_comb begin
        sample_tick = tick;
        bit_end     = wrap;
        half_bit    = mid;
    end

endmodule

// File: rtl/baud_tick_chk.sv
// Assertion checker for baud_tick_gen, bound to every instance of it.
module baud_tick_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_sel,
    input logic             alt_en,
    input logic [DIV_W-1:0] int_div,
    input logic             frame_start,
    input logic             sample_tick,
    input logic             bit_end,
    input logic             half_bit
);
    // R7: a zero divisor silences the tick
    a_r7_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (int_div == '0) |-> !sample_tick);

    // R5: bit end only together with a tick
    a_r5_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> sample_tick);

    // R6: half-bit only together with a tick, never on the last tick
    a_r6_half_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        half_bit |-> (sample_tick && !bit_end));

    // R8: nothing is emitted in a restart cycle
    a_r8_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !(sample_tick || bit_end || half_bit));

    // R9: alternate source counts only enabled cycles
    a_r9_alt_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && !alt_en) |-> !sample_tick);

    // R2: a divisor of two or more never gives back-to-back ticks
    a_r2_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && int_div >= DIV_W'(2)) |=> (int_div < DIV_W'(2) || !sample_tick));

    // R1: outputs are held low in reset
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!(sample_tick || bit_end || half_bit));
        end
    end

endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .alt_en      (alt_en),
    .int_div     (int_div),
    .frame_start (frame_start),
    .sample_tick (sample_tick),
    .bit_end     (bit_end),
    .half_bit    (half_bit)
);

// File: tb/sim_baud_tick_gen.sv
// Self-checking bench: drives at the falling edge, samples one time unit
// before the rising edge, and predicts every tick from the requirements.
module sim_baud_tick_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        src_sel;
    logic        alt_en;
    logic [11:0] int_div;
    logic [6:0]  frac_div;
    logic [2:0]  factor_code;
    logic        acc_mode;
    logic        frame_start;
    logic        sample_tick;
    logic        bit_end;
    logic        half_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_sel     (src_sel),
        .alt_en      (alt_en),
        .int_div     (int_div),
        .frac_div    (frac_div),
        .factor_code (factor_code),
        .acc_mode    (acc_mode),
        .frame_start (frame_start),
        .sample_tick (sample_tick),
        .bit_end     (bit_end),
        .half_bit    (half_bit)
    );

    function automatic int factor_of(int code);
        if (code > 3) return 16;
        return 128 >> code;
    endfunction

    function automatic int carry_of(bit mode, int f, int fac, int k);
        int j;
        j = mode ? (k % fac) : k;
        return ((j + 1) * f) / 128 - (j * f) / 128;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One case: frame start, then ncyc cycles compared against the predicted schedule.
    task automatic run_case(string tag, int d, int f, int code, bit mode, bit src, int ncyc);
        int  fac;
        int  k;
        int  q;
        bit  qual;
        bit  et;
        bit  eb;
        bit  eh;
        bit  bad;
        fac = factor_of(code);
        k   = 0;
        q   = 0;
        bad = 1'b0;
        @(negedge clk);
        int_div     = 12'(d);
        frac_div    = 7'(f);
        factor_code = 3'(code);
        acc_mode    = mode;
        src_sel     = src;
        alt_en      = 1'($urandom % 2);
        frame_start = 1'b1;
        #(CLK_PERIOD/2 - 1);
        // R8: restart cycle is quiet
        check(!(sample_tick || bit_end || half_bit), {tag, " R8"}, "outputs in start cycle",
              int'({sample_tick, bit_end, half_bit}), 0);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            frame_start = 1'b0;
            alt_en      = 1'($urandom % 2);
            #(CLK_PERIOD/2 - 1);
            qual = !src || alt_en;
            et = 1'b0;
            eb = 1'b0;
            eh = 1'b0;
            if (qual && d != 0) begin
                q++;
                if (q == d + carry_of(mode, f, fac, k)) begin
                    et = 1'b1;
                    eb = (k % fac) == fac - 1;
                    eh = (k % fac) == fac / 2 - 1;
                    q  = 0;
                    k++;
                end
            end
            if (et || sample_tick || bit_end || half_bit) begin
                check({sample_tick, bit_end, half_bit} == {et, eb, eh}, tag,
                      $sformatf("tick/end/half at cycle %0d tick %0d", c, k),
                      int'({sample_tick, bit_end, half_bit}), int'({et, eb, eh}));
                if ({sample_tick, bit_end, half_bit} != {et, eb, eh}) begin
                    bad = 1'b1;
                    break;
                end
            end
        end
        if (!bad) begin
            if (d == 0) check(k == 0, {tag, " R7"}, "ticks with zero divisor", k, 0);
            else        check(k > 0, tag, "case produced ticks", k, 1);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n       = 1'b0;
        src_sel     = 1'b0;
        alt_en      = 1'b0;
        int_div     = 12'd1;
        frac_div    = 7'd0;
        factor_code = 3'd3;
        acc_mode    = 1'b0;
        frame_start = 1'b0;

        // R1: outputs low in reset even with a divisor of one
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #(CLK_PERIOD/2 - 1);
            check(!(sample_tick || bit_end || half_bit), "R1", "outputs in reset",
                  int'({sample_tick, bit_end, half_bit}), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/2 - 1);
        check(sample_tick == 1'b1, "R1", "tick in first cycle after reset", int'(sample_tick), 1);

        // Directed corners
        run_case("R7 zero divisor",         0,  50, 3, 1'b0, 1'b0, 300);
        run_case("R2 integer only",         3,   0, 3, 1'b0, 1'b0, 400);
        run_case("R3 frame mode f37",       2,  37, 3, 1'b0, 1'b0, 600);
        run_case("R4 bit mode f37",         2,  37, 3, 1'b1, 1'b0, 600);
        run_case("R3 f127 divisor 1",       1, 127, 3, 1'b0, 1'b0, 400);
        run_case("R5 R6 factor 128",        1,   5, 0, 1'b0, 1'b0, 800);
        run_case("R5 clamped code 5",       2,  20, 5, 1'b1, 1'b0, 400);
        run_case("R9 alternate source",     2,  90, 2, 1'b0, 1'b1, 1500);
        run_case("R9 alt_en ignored",       2,  90, 2, 1'b1, 1'b0, 1000);

        // Random mix
        for (int n = 0; n < 10; n++) begin
            run_case("R3 R4 R5 R6 R8 R9 random",
                     1 + int'($urandom % 6), int'($urandom % 128), int'($urandom % 8),
                     1'($urandom % 2), 1'($urandom % 2), 4000);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule